// File: doc/BRIEF.md
# Sync Capture Timing-Margin Checker

This block judges whether a one-sample-period synchronization pulse is being captured safely by the sample clock. It runs on an oversampling clock. A strobe marks the oversample tick on which the sample clock captures the pulse. The block compares that nominal capture with the pulse value at every tick up to N ticks earlier and up to N ticks later, where N is a 4-bit margin input. If any displaced sample differs from the nominal one, the pulse is too close to the capture edge for that margin, and a sticky interrupt is raised.

The block does not report whether the fault is on the early (setup) side or on the late (hold) side. An interrupt means that the pulse edge falls inside the window on at least one side. To find the usable margin, software can raise the margin step by step until the interrupt appears. The interrupt stays set until it is cleared explicitly or the block is reset.

To see the late samples, the comparison waits for them. The block keeps a history of the pulse that spans twice the largest margin, and it delays the strobe by the largest margin before it compares.

Top module: `sync_margin_det`

## Requirements
- R1: After reset, `irq_o` is 0.
- R2: When `strobe_i` has not been high, no activity on `pulse_i` sets `irq_o`.
- R3: When `margin_i` is 0, a strobed capture never sets `irq_o`, whatever the pulse waveform.
- R4: A strobe on oversample edge t, with margin m (1..MAX_MARGIN), sets `irq_o` if and only if the pulse value sampled on some edge t±k (1 ≤ k ≤ m) differs from the value sampled on edge t. Both sides are checked, and it makes no difference which side differs.
- R5: An interrupt caused by the strobe on edge t is first visible after edge t+MAX_MARGIN+1. It is still 0 after edge t+MAX_MARGIN.
- R6: Once set, `irq_o` stays 1 until a clear or a reset.
- R7: `irq_clr_i` high on an edge with no new mismatch drives `irq_o` to 0 after that edge.
- R8: If a mismatch and `irq_clr_i` land on the same edge, the set wins and `irq_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Sample-clock capture tick |
| pulse_i | input | 1 | Edge-detector output pulse under test |
| margin_i | input | 4 | Window half-width in oversample ticks; 0 disables the check |
| irq_clr_i | input | 1 | Clears the sticky interrupt |
| irq_o | output | 1 | Sticky timing-margin interrupt |

## Verification
A delayed comparison can set the interrupt on the same edge that software clears it. The bench provokes this by placing a failing strobe and then asserting the clear exactly MAX_MARGIN+1 edges later, so that the clear coincides with the set. It judges the result by requiring `irq_o` to be 1 afterwards. A separate clear with no mismatch pending must then drop `irq_o`. The main sweep covers pulse position, width and margin, and each expected outcome is computed from interval arithmetic on the window [t−m, t+m].

// File: rtl/sync_margin_pkg.sv
package sync_margin_pkg;
  localparam int unsigned MARGIN_W = 4;
  typedef logic [MARGIN_W-1:0] margin_t;
endpackage

// File: rtl/sync_sample_hist.sv
module sync_sample_hist #(
  parameter int unsigned MAX_MARGIN = 15,
  localparam int unsigned HIST_W = 2 * MAX_MARGIN + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pulse_i,
  input  logic              strobe_i,
  output logic [HIST_W-1:0] hist_o,
  output logic              cmp_en_o
);
  logic [MAX_MARGIN:0] strb_q;

  // hist_o[i] holds the pulse sampled i edges ago
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_o <= '0;
      strb_q <= '0;
    end else begin
      hist_o <= {hist_o[HIST_W-2:0], pulse_i};
      strb_q <= {strb_q[MAX_MARGIN-1:0], strobe_i};
    end
  end

  // strobe aged MAX_MARGIN edges: the centre of the history is the nominal capture
  assign cmp_en_o = strb_q[MAX_MARGIN];
endmodule

// File: rtl/sync_margin_cmp.sv
module sync_margin_cmp
  import sync_margin_pkg::*;
#(
  parameter int unsigned MAX_MARGIN = 15,
  localparam int unsigned HIST_W = 2 * MAX_MARGIN + 1
) (
  input  logic [HIST_W-1:0] hist_i,
  input  logic              cmp_en_i,
  input  margin_t           margin_i,
  output logic              mismatch_o
);
  logic              centre;
  logic [MAX_MARGIN-1:0] diff;

  assign centre = hist_i[MAX_MARGIN];

  for (genvar k = 1; k <= MAX_MARGIN; k++) begin : g_tap
    localparam margin_t KV = margin_t'(k);
    logic early_d, late_d;
    assign early_d = hist_i[MAX_MARGIN+k] ^ centre;
    assign late_d  = hist_i[MAX_MARGIN-k] ^ centre;
    assign diff[k-1] = (margin_i >= KV) && (early_d || late_d);
  end

  assign mismatch_o = cmp_en_i && (|diff);
endmodule

// File: rtl/sync_irq_reg.sv
module sync_irq_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    irq_o <= 1'b0;
    else if (set_i) irq_o <= 1'b1;   // set beats clear
    else if (clr_i) irq_o <= 1'b0;
  end
endmodule

// File: rtl/sync_margin_det.sv
module sync_margin_det
  import sync_margin_pkg::*;
#(
  parameter int unsigned MAX_MARGIN = 15
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       strobe_i,
  input  logic       pulse_i,
  input  logic [3:0] margin_i,
  input  logic       irq_clr_i,
  output logic       irq_o
);
  localparam int unsigned HIST_W = 2 * MAX_MARGIN + 1;

  logic [HIST_W-1:0] hist_w;
  logic              cmp_en_w;
  logic              set_w;

  sync_sample_hist #(.MAX_MARGIN(MAX_MARGIN)) u_hist (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pulse_i  (pulse_i),
    .strobe_i (strobe_i),
    .hist_o   (hist_w),
    .cmp_en_o (cmp_en_w)
  );

  sync_margin_cmp #(.MAX_MARGIN(MAX_MARGIN)) u_cmp (
    .hist_i     (hist_w),
    .cmp_en_i   (cmp_en_w),
    .margin_i   (margin_t'(margin_i)),
    .mismatch_o (set_w)
  );

  sync_irq_reg u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_w),
    .clr_i  (irq_clr_i),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/sync_margin_det_chk.sv
module sync_margin_det_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [3:0] margin_i,
  input logic       irq_clr_i,
  input logic       irq_o,
  input logic       set_w,
  input logic       cmp_en_w
);
  assert_no_rise_without_cmp_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(cmp_en_w));

  assert_zero_margin_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_en_w && margin_i == 4'd0) |-> !set_w);

  assert_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_clr_i) |=> irq_o);

  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_clr_i && !set_w) |=> !irq_o);

  assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_w |=> irq_o);
endmodule

bind sync_margin_det sync_margin_det_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .margin_i  (margin_i),
  .irq_clr_i (irq_clr_i),
  .irq_o     (irq_o),
  .set_w     (set_w),
  .cmp_en_w  (cmp_en_w)
);

// File: tb/sync_margin_det_tb.sv
module sync_margin_det_tb;
  localparam int MAXM = 15;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strobe = 1'b0;
  logic       pulse = 1'b0;
  logic [3:0] margin = 4'd0;
  logic       clr = 1'b0;
  logic       irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sync_margin_det #(.MAX_MARGIN(MAXM)) u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .strobe_i  (strobe),
    .pulse_i   (pulse),
    .margin_i  (margin),
    .irq_clr_i (clr),
    .irq_o     (irq)
  );

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s irq actual=%b expected=%b", req, act, exp);
    end
  endtask

  // one trial: strobe on edge 0, pulse high on edges a..a+len-1
  task automatic trial(input int m, input int a, input int len, input bit clr_on_set);
    bit all_in, all_out, exp;
    all_in  = (a <= -m) && (a + len - 1 >= m);
    all_out = (a > m) || (a + len - 1 < -m);
    exp     = (m != 0) && !all_in && !all_out;
    @(negedge clk);
    margin = 4'(m); pulse = 1'b0; strobe = 1'b0; clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    for (int rel = -20; rel <= 20; rel++) begin
      @(negedge clk);
      if (rel == MAXM + 1) check("R5", irq, 1'b0);
      if (rel == MAXM + 2) check(m == 0 ? "R3" : "R4", irq, exp || clr_on_set);
      pulse  = (rel >= a) && (rel <= a + len - 1);
      strobe = (rel == 0);
      clr    = clr_on_set && (rel == MAXM + 1);
    end
    @(negedge clk);
    pulse = 1'b0; strobe = 1'b0; clr = 1'b0;
  endtask

  initial begin
    int ms[7] = '{0, 1, 2, 3, 5, 8, 15};
    int ls[4] = '{1, 5, 12, 33};
    repeat (3) @(negedge clk);
    check("R1", irq, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", irq, 1'b0);

    // R2: pulse activity with no strobe
    margin = 4'd15;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      pulse = i[1] ^ i[3];
    end
    repeat (20) @(negedge clk);
    check("R2", irq, 1'b0);
    pulse = 1'b0;

    // R3/R4/R5 sweep over margin, pulse position and width
    for (int mi = 0; mi < 7; mi++)
      for (int li = 0; li < 4; li++)
        for (int a = -18; a <= 18; a++)
          trial(ms[mi], a, ls[li], 1'b0);

    // R8: mismatch and clear on the same edge (pulse edge at +1, margin 2)
    trial(2, 1, 5, 1'b1);
    // R6: stays set with no clear
    repeat (30) @(negedge clk);
    check("R6", irq, 1'b1);
    // R7: clear with nothing pending
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    check("R7", irq, 1'b0);
    // R8 also on a late-side-only mismatch whose value at the capture is 0
    trial(4, 3, 1, 1'b1);
    check("R8", irq, 1'b1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule